// File: doc/BRIEF.md
# DRAM Bank Row Scheduler

This block sits between request sources and an external DRAM command path. It accepts byte-addressed read and write requests into a small queue. It splits each address into bank, row and column, with consecutive row-sized chunks of the address space rotating across the banks. It keeps one open-row register per bank and issues abstract commands to the device: row open, column read, column write and row close.

Each time the scheduler is free, it picks one queued request. A request whose row is already open is preferred over one that needs a row change. Among the open-row hits, one in the same direction as the last column command is preferred, so that reads and writes tend to run in batches. Two requests to the same burst address always keep their arrival order. A request left waiting at the queue head while younger ones are served is forced through after a set number of bypasses. The row-close to row-open gap, the row-open to column gap and the read/write turnaround gap are parameters. Rows stay open after an access.

The FSM has four states. IDLE picks a request. From IDLE it moves to COL on a hit, to PRE_WAIT after issuing a row close when another row is open, and to ACT_WAIT after issuing a row open when the bank is closed. PRE_WAIT issues the row open when its counter runs out and moves to ACT_WAIT. ACT_WAIT moves to COL when its counter runs out. COL issues the column command once the turnaround rule allows it, removes the request from the queue and returns to IDLE.

Top module: `dram_sched`

## Requirements
- R1: With default parameters, the column is req_addr[10:5], the bank is req_addr[12:11] and the row is req_addr[19:13]. Address bits [4:0] are ignored, because every access moves one whole 32-byte burst.
- R2: Linear addresses k*2048 for k = 0,1,2,... map to banks k mod 4.
- R3: A row open (cmd_op=0) goes only to a closed bank, and a row close (cmd_op=3) goes only to an open bank. A column read (1) or write (2) goes only to a bank whose open row equals cmd_row. A bank holding another row is closed first, even if that row was only read.
- R4: A request that hits its bank's open row is served before an older request that needs a different row in the same bank.
- R5: Among open-row hits, one in the same direction as the last column command is served before an older one in the opposite direction.
- R6: Two consecutive column commands of opposite direction are at least T_TURN cycles apart.
- R7: Once the queue-head request has been bypassed STARVE_LIM times, it is served next.
- R8: A row open comes at least T_RP cycles after a row close to the same bank. A column command comes at least T_RCD cycles after the row open of its bank.
- R9: Requests to the same burst address are served in arrival order, whatever their direction.
- R10: Each accepted request produces exactly one column command. req_ready is low while the QDEPTH-entry queue is full.
- R11: After reset, req_ready is high, no command is issued, and all banks are closed, so the first access to a bank starts with a row open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_ready | output | 1 | Queue can accept a request |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 2 | 0 open row, 1 read, 2 write, 3 close row |
| cmd_bank | output | BANK_W | Target bank |
| cmd_row | output | ROW_W | Target row |
| cmd_col | output | COL_W | Target burst column |

## Verification
Starvation is the hardest case to reach from the ports. The head request must be a row miss, and enough younger open-row hits must reach the queue before it is picked. The stimulus first queues a slow miss to another bank to keep the scheduler busy, then fills the queue behind it with one miss followed by hits to an open row. The same busy-first trick sets up the hit-bypass, direction-batching and same-address cases. A seeded random phase draws addresses from a tiny pool, which makes row hits and same-address collisions frequent.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } dsq_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE_WAIT,
        ST_ACT_WAIT,
        ST_COL
    } dsq_state_e;
endpackage

// File: rtl/dsq_addr_map.sv
module dsq_addr_map #(
    parameter int ADDR_W   = 20,
    parameter int BANK_W   = 2,
    parameter int ROW_LG   = 11,
    parameter int BURST_LG = 5,
    parameter int ROW_W    = ADDR_W - ROW_LG - BANK_W,
    parameter int COL_W    = ROW_LG - BURST_LG
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    // row-sized chunks rotate across banks; bytes inside a burst are dropped
    assign col  = addr[BURST_LG +: COL_W];
    assign bank = addr[ROW_LG +: BANK_W];
    assign row  = addr[ROW_LG + BANK_W +: ROW_W];
endmodule

// File: rtl/dsq_queue.sv
module dsq_queue #(
    parameter int QDEPTH = 4,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 7,
    parameter int COL_W  = 6,
    parameter int SKIP_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              push_wr,
    input  logic [BANK_W-1:0] push_bank,
    input  logic [ROW_W-1:0]  push_row,
    input  logic [COL_W-1:0]  push_col,
    input  logic              pop,
    input  logic [IDX_W-1:0]  pop_idx,
    input  logic              bump,
    input  logic [IDX_W-1:0]  bump_idx,
    output logic              q_vld  [QDEPTH],
    output logic              q_wr   [QDEPTH],
    output logic [BANK_W-1:0] q_bank [QDEPTH],
    output logic [ROW_W-1:0]  q_row  [QDEPTH],
    output logic [COL_W-1:0]  q_col  [QDEPTH],
    output logic [SKIP_W-1:0] q_skip [QDEPTH],
    output logic              full
);
    logic              r_vld [QDEPTH], n_vld [QDEPTH];
    logic              r_wr  [QDEPTH], n_wr  [QDEPTH];
    logic [BANK_W-1:0] r_bank[QDEPTH], n_bank[QDEPTH];
    logic [ROW_W-1:0]  r_row [QDEPTH], n_row [QDEPTH];
    logic [COL_W-1:0]  r_col [QDEPTH], n_col [QDEPTH];
    logic [SKIP_W-1:0] r_skip[QDEPTH], n_skip[QDEPTH];

    always_comb begin
        logic placed;
        for (int i = 0; i < QDEPTH; i++) begin
            n_vld[i]  = r_vld[i];
            n_wr[i]   = r_wr[i];
            n_bank[i] = r_bank[i];
            n_row[i]  = r_row[i];
            n_col[i]  = r_col[i];
            n_skip[i] = r_skip[i];
        end
        // older entries passed over by the current pick age by one
        if (bump) begin
            for (int i = 0; i < QDEPTH; i++) begin
                if (i < int'(bump_idx) && n_vld[i] && n_skip[i] != '1)
                    n_skip[i] = n_skip[i] + 1'b1;
            end
        end
        // compact the queue so index 0 stays the oldest
        if (pop) begin
            for (int i = 0; i < QDEPTH - 1; i++) begin
                if (i >= int'(pop_idx)) begin
                    n_vld[i]  = n_vld[i+1];
                    n_wr[i]   = n_wr[i+1];
                    n_bank[i] = n_bank[i+1];
                    n_row[i]  = n_row[i+1];
                    n_col[i]  = n_col[i+1];
                    n_skip[i] = n_skip[i+1];
                end
            end
            n_vld[QDEPTH-1] = 1'b0;
        end
        placed = 1'b0;
        for (int i = 0; i < QDEPTH; i++) begin
            if (push && !placed && !n_vld[i]) begin
                n_vld[i]  = 1'b1;
                n_wr[i]   = push_wr;
                n_bank[i] = push_bank;
                n_row[i]  = push_row;
                n_col[i]  = push_col;
                n_skip[i] = '0;
                placed    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < QDEPTH; i++) begin
            if (!rst_n) begin
                r_vld[i]  <= 1'b0;
                r_wr[i]   <= 1'b0;
                r_bank[i] <= '0;
                r_row[i]  <= '0;
                r_col[i]  <= '0;
                r_skip[i] <= '0;
            end else begin
                r_vld[i]  <= n_vld[i];
                r_wr[i]   <= n_wr[i];
                r_bank[i] <= n_bank[i];
                r_row[i]  <= n_row[i];
                r_col[i]  <= n_col[i];
                r_skip[i] <= n_skip[i];
            end
        end
    end

    assign q_vld  = r_vld;
    assign q_wr   = r_wr;
    assign q_bank = r_bank;
    assign q_row  = r_row;
    assign q_col  = r_col;
    assign q_skip = r_skip;
    assign full   = r_vld[QDEPTH-1];
endmodule

// File: rtl/dsq_picker.sv
module dsq_picker #(
    parameter int QDEPTH     = 4,
    parameter int NUM_BANKS  = 4,
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 7,
    parameter int COL_W      = 6,
    parameter int SKIP_W     = 2,
    parameter int IDX_W      = 2,
    parameter int STARVE_LIM = 2
) (
    input  logic                 q_vld  [QDEPTH],
    input  logic                 q_wr   [QDEPTH],
    input  logic [BANK_W-1:0]    q_bank [QDEPTH],
    input  logic [ROW_W-1:0]     q_row  [QDEPTH],
    input  logic [COL_W-1:0]     q_col  [QDEPTH],
    input  logic [SKIP_W-1:0]    q_skip [QDEPTH],
    input  logic [NUM_BANKS-1:0] open_vld,
    input  logic [ROW_W-1:0]     open_row [NUM_BANKS],
    input  logic                 last_wr,
    output logic                 any,
    output logic [IDX_W-1:0]     sel
);
    always_comb begin
        logic       elig;
        logic       hit;
        logic [2:0] score;
        logic [2:0] best;
        best = '0;
        sel  = '0;
        for (int i = 0; i < QDEPTH; i++) begin
            elig = q_vld[i];
            // an older request to the same burst blocks this one
            for (int j = 0; j < i; j++) begin
                if (q_vld[j] && q_bank[j] == q_bank[i] &&
                    q_row[j] == q_row[i] && q_col[j] == q_col[i])
                    elig = 1'b0;
            end
            hit   = open_vld[q_bank[i]] && (open_row[q_bank[i]] == q_row[i]);
            score = {1'b0, hit, q_wr[i] == last_wr} + 3'd1;
            if (elig && score > best) begin
                best = score;
                sel  = IDX_W'(i);
            end
        end
        // the head always ages fastest, so it is the one that can starve
        if (q_vld[0] && q_skip[0] >= SKIP_W'(STARVE_LIM))
            sel = '0;
    end

    assign any = q_vld[0];
endmodule

// File: rtl/dram_sched.sv
module dram_sched
    import dsq_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int ADDR_W       = 20,
    parameter int ROW_BYTES_LG = 11,
    parameter int BURST_LG     = 5,
    parameter int QDEPTH       = 4,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_TURN       = 4,
    parameter int STARVE_LIM   = 2,
    localparam int BANK_W      = $clog2(NUM_BANKS),
    localparam int ROW_W       = ADDR_W - ROW_BYTES_LG - BANK_W,
    localparam int COL_W       = ROW_BYTES_LG - BURST_LG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col
);
    localparam int IDX_W  = $clog2(QDEPTH);
    localparam int SKIP_W = $clog2(STARVE_LIM + 2);
    localparam int CNT_W  = $clog2((T_RCD > T_RP ? T_RCD : T_RP) + 1) + 1;
    localparam int TRN_W  = $clog2(T_TURN + 1) + 1;

    logic [BANK_W-1:0] in_bank;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;

    dsq_addr_map #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_LG(ROW_BYTES_LG), .BURST_LG(BURST_LG),
        .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_map (
        .addr(req_addr), .bank(in_bank), .row(in_row), .col(in_col)
    );

    logic              q_vld  [QDEPTH];
    logic              q_wr   [QDEPTH];
    logic [BANK_W-1:0] q_bank [QDEPTH];
    logic [ROW_W-1:0]  q_row  [QDEPTH];
    logic [COL_W-1:0]  q_col  [QDEPTH];
    logic [SKIP_W-1:0] q_skip [QDEPTH];
    logic              q_full, pop, bump, any;
    logic [IDX_W-1:0]  sel, cur, tgt;

    assign req_ready = !q_full;

    dsq_queue #(
        .QDEPTH(QDEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .SKIP_W(SKIP_W), .IDX_W(IDX_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(req_valid && req_ready), .push_wr(req_write),
        .push_bank(in_bank), .push_row(in_row), .push_col(in_col),
        .pop(pop), .pop_idx(cur), .bump(bump), .bump_idx(sel),
        .q_vld(q_vld), .q_wr(q_wr), .q_bank(q_bank), .q_row(q_row),
        .q_col(q_col), .q_skip(q_skip), .full(q_full)
    );

    logic [NUM_BANKS-1:0] open_vld;
    logic [ROW_W-1:0]     open_row [NUM_BANKS];
    logic                 last_wr;
    logic [TRN_W-1:0]     since_col;

    dsq_picker #(
        .QDEPTH(QDEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .COL_W(COL_W), .SKIP_W(SKIP_W), .IDX_W(IDX_W), .STARVE_LIM(STARVE_LIM)
    ) u_pick (
        .q_vld(q_vld), .q_wr(q_wr), .q_bank(q_bank), .q_row(q_row), .q_col(q_col),
        .q_skip(q_skip), .open_vld(open_vld), .open_row(open_row),
        .last_wr(last_wr), .any(any), .sel(sel)
    );

    dsq_state_e       state, state_n;
    dsq_op_e          op;
    logic [CNT_W-1:0] cnt, cnt_val;
    logic             cnt_ld, t_open, t_hit, turn_ok;

    assign tgt     = (state == ST_IDLE) ? sel : cur;
    assign t_open  = open_vld[q_bank[tgt]];
    assign t_hit   = t_open && (open_row[q_bank[tgt]] == q_row[tgt]);
    assign turn_ok = (q_wr[tgt] == last_wr) || (since_col >= TRN_W'(T_TURN));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n   = state;
        cmd_valid = 1'b0;
        op        = OP_ACT;
        bump      = 1'b0;
        pop       = 1'b0;
        cnt_ld    = 1'b0;
        cnt_val   = '0;
        unique case (state)
            ST_IDLE: begin
                if (any) begin
                    bump = 1'b1;
                    if (t_hit) begin
                        state_n = ST_COL;
                    end else if (t_open) begin
                        cmd_valid = 1'b1;
                        op        = OP_PRE;
                        cnt_ld    = 1'b1;
                        cnt_val   = CNT_W'(T_RP - 1);
                        state_n   = ST_PRE_WAIT;
                    end else begin
                        cmd_valid = 1'b1;
                        op        = OP_ACT;
                        cnt_ld    = 1'b1;
                        cnt_val   = CNT_W'(T_RCD - 1);
                        state_n   = ST_ACT_WAIT;
                    end
                end
            end
            ST_PRE_WAIT: begin
                if (cnt == '0) begin
                    cmd_valid = 1'b1;
                    op        = OP_ACT;
                    cnt_ld    = 1'b1;
                    cnt_val   = CNT_W'(T_RCD - 1);
                    state_n   = ST_ACT_WAIT;
                end
            end
            ST_ACT_WAIT: begin
                if (cnt == '0) state_n = ST_COL;
            end
            ST_COL: begin
                if (turn_ok) begin
                    cmd_valid = 1'b1;
                    op        = q_wr[tgt] ? OP_WR : OP_RD;
                    pop       = 1'b1;
                    state_n   = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        cmd_op   = op;
        cmd_bank = q_bank[tgt];
        cmd_row  = q_row[tgt];
        cmd_col  = q_col[tgt];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            cur       <= '0;
            open_vld  <= '0;
            last_wr   <= 1'b0;
            since_col <= TRN_W'(T_TURN);
            for (int b = 0; b < NUM_BANKS; b++) open_row[b] <= '0;
        end else begin
            if (cnt_ld)          cnt <= cnt_val;
            else if (cnt != '0)  cnt <= cnt - 1'b1;
            if (state == ST_IDLE && any) cur <= sel;
            if (cmd_valid && op == OP_ACT) begin
                open_vld[cmd_bank] <= 1'b1;
                open_row[cmd_bank] <= cmd_row;
            end
            if (cmd_valid && op == OP_PRE) open_vld[cmd_bank] <= 1'b0;
            if (pop) begin
                last_wr   <= q_wr[tgt];
                since_col <= '0;
            end else if (since_col < TRN_W'(T_TURN)) begin
                since_col <= since_col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsq_sched_chk.sv
module dsq_sched_chk
    import dsq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 7,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_TURN    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ROW_W-1:0]  cmd_row
);
    localparam int GAP_W = $clog2(T_RCD + T_RP + T_TURN + 2) + 1;

    logic             m_open [NUM_BANKS];
    logic [ROW_W-1:0] m_row  [NUM_BANKS];
    logic [GAP_W-1:0] g_pre  [NUM_BANKS];
    logic [GAP_W-1:0] g_act  [NUM_BANKS];
    logic [GAP_W-1:0] g_col;
    logic             l_wr, seen_col, is_col, is_wr;

    assign is_col = cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR);
    assign is_wr  = (cmd_op == OP_WR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_col    <= '1;
            l_wr     <= 1'b0;
            seen_col <= 1'b0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                m_open[b] <= 1'b0;
                m_row[b]  <= '0;
                g_pre[b]  <= '1;
                g_act[b]  <= '1;
            end
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (cmd_valid && cmd_bank == BANK_W'(b) && cmd_op == OP_ACT) begin
                    m_open[b] <= 1'b1;
                    m_row[b]  <= cmd_row;
                    g_act[b]  <= 1;
                end else if (g_act[b] != '1) g_act[b] <= g_act[b] + 1'b1;
                if (cmd_valid && cmd_bank == BANK_W'(b) && cmd_op == OP_PRE) begin
                    m_open[b] <= 1'b0;
                    g_pre[b]  <= 1;
                end else if (g_pre[b] != '1) g_pre[b] <= g_pre[b] + 1'b1;
            end
            if (is_col) begin
                g_col    <= 1;
                l_wr     <= is_wr;
                seen_col <= 1'b1;
            end else if (g_col != '1) g_col <= g_col + 1'b1;
        end
    end

    assert_act_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACT) |-> !m_open[cmd_bank]);
    assert_pre_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PRE) |-> m_open[cmd_bank]);
    assert_col_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (m_open[cmd_bank] && m_row[cmd_bank] == cmd_row));
    assert_trp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACT) |-> (g_pre[cmd_bank] >= GAP_W'(T_RP)));
    assert_trcd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (g_act[cmd_bank] >= GAP_W'(T_RCD)));
    assert_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && seen_col && is_wr != l_wr) |-> (g_col >= GAP_W'(T_TURN)));
endmodule

bind dram_sched dsq_sched_chk #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_TURN(T_TURN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row)
);

// File: tb/dram_sched_test.sv
module dram_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_RCD = 3, T_RP = 3, T_TURN = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_ready, cmd_valid;
    logic [1:0]  cmd_op;
    logic [1:0]  cmd_bank;
    logic [6:0]  cmd_row;
    logic [5:0]  cmd_col;

    dram_sched uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_ready(req_ready), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;
    int lg_op[256], lg_bank[256], lg_col[256], lg_cyc[256], lg_n = 0;
    int sv_id[1024], sv_n = 0;
    int p_addr[64], p_wr[64], p_id[64], p_n = 0, next_id = 0;
    int m_open[4], m_row[4], t_pre[4], t_act[4];
    int t_col = -1000, l_wr = 0;
    bit done = 0;

    function automatic int f_bank(int a); return (a >> 11) & 3;   endfunction
    function automatic int f_row(int a);  return (a >> 13) & 127; endfunction
    function automatic int f_col(int a);  return (a >> 5) & 63;   endfunction
    function automatic int mk(int row, int bank, int col, int lo);
        return (row << 13) | (bank << 11) | (col << 5) | lo;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial for (int b = 0; b < 4; b++) begin
        m_open[b] = 0; m_row[b] = 0; t_pre[b] = -1000; t_act[b] = -1000;
    end

    // bank model and command-stream checks
    always @(negedge clk) begin
        cyc++;
        if (rst_n && cmd_valid) begin
            int b, k, w;
            b = int'(cmd_bank);
            if (lg_n < 256) begin
                lg_op[lg_n] = int'(cmd_op); lg_bank[lg_n] = b;
                lg_col[lg_n] = int'(cmd_col); lg_cyc[lg_n] = cyc; lg_n++;
            end
            case (cmd_op)
                2'd0: begin
                    chk(m_open[b] == 0, "R3 open to closed bank", m_open[b], 0);
                    chk(cyc - t_pre[b] >= T_RP, "R8 tRP gap", cyc - t_pre[b], T_RP);
                    m_open[b] = 1; m_row[b] = int'(cmd_row); t_act[b] = cyc;
                end
                2'd3: begin
                    chk(m_open[b] == 1, "R3 close of open bank", m_open[b], 1);
                    m_open[b] = 0; t_pre[b] = cyc;
                end
                default: begin
                    w = (cmd_op == 2'd2);
                    chk(m_open[b] == 1 && m_row[b] == int'(cmd_row), "R3 column row",
                        int'(cmd_row), m_row[b]);
                    chk(cyc - t_act[b] >= T_RCD, "R8 tRCD gap", cyc - t_act[b], T_RCD);
                    if (w != l_wr)
                        chk(cyc - t_col >= T_TURN, "R6 turnaround", cyc - t_col, T_TURN);
                    t_col = cyc; l_wr = w;
                    k = -1;
                    for (int i = 0; i < p_n; i++)
                        if (k < 0 && f_bank(p_addr[i]) == b && f_row(p_addr[i]) == int'(cmd_row)
                            && f_col(p_addr[i]) == int'(cmd_col)) k = i;
                    chk(k >= 0, "R10 column matches a request", k, 0);
                    if (k >= 0) begin
                        chk(p_wr[k] == w, "R9 same-address order", w, p_wr[k]);
                        if (sv_n < 1024) begin sv_id[sv_n] = p_id[k]; sv_n++; end
                        for (int i = k; i < p_n - 1; i++) begin
                            p_addr[i] = p_addr[i+1]; p_wr[i] = p_wr[i+1]; p_id[i] = p_id[i+1];
                        end
                        p_n--;
                    end
                end
            endcase
        end
    end

    task automatic push_req(int w, int a);
        req_valid = 1'b1; req_write = w[0]; req_addr = 20'(a);
        while (!req_ready) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
        p_addr[p_n] = a; p_wr[p_n] = w; p_id[p_n] = next_id; p_n++; next_id++;
    endtask

    task automatic drain();
        int t = 0;
        while (p_n != 0 && t < 3000) begin @(posedge clk); #1; t++; end
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic expect_order(int s, int n, int exp0, int exp1, int exp2, int exp3, int exp4, string tag);
        int e[5];
        e = '{exp0, exp1, exp2, exp3, exp4};
        for (int i = 0; i < n; i++)
            chk(sv_id[s + i] == e[i], tag, sv_id[s + i], e[i]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(req_ready == 1'b1, "R11 ready during reset", req_ready, 1);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R11 idle after reset", cmd_valid, 0);

        begin // R1 / R11: single read, low bits ignored
            lg_n = 0;
            push_req(0, mk(5, 2, 9, 31));
            drain();
            chk(lg_n == 2, "R11 open then read", lg_n, 2);
            chk(lg_op[0] == 0 && lg_bank[0] == 2, "R11 first command opens bank 2", lg_op[0], 0);
            chk(lg_op[1] == 1 && lg_col[1] == 9, "R1 burst column", lg_col[1], 9);
        end

        begin // R2 / R3: consecutive row-sized chunks
            int s, nrd, pre0;
            lg_n = 0; s = sv_n;
            for (int k = 0; k < 5; k++) push_req(0, k * 2048);
            drain();
            nrd = 0; pre0 = 0;
            for (int i = 0; i < lg_n; i++) begin
                if (lg_op[i] == 1) begin
                    chk(lg_bank[i] == nrd % 4, "R2 bank rotation", lg_bank[i], nrd % 4);
                    nrd++;
                end
                if (lg_op[i] == 3 && lg_bank[i] == 0) pre0 = 1;
            end
            chk(nrd == 5, "R10 five reads", nrd, 5);
            chk(pre0 == 1, "R3 close after read-only row", pre0, 1);
        end

        begin // R4: hit bypasses older miss in same bank (bank0 holds row 1)
            int s, b;
            s = sv_n; b = next_id;
            push_req(0, mk(7, 1, 0, 0));
            push_req(0, mk(2, 0, 3, 0));
            push_req(0, mk(1, 0, 4, 0));
            drain();
            expect_order(s, 3, b, b + 2, b + 1, 0, 0, "R4 hit first");
        end

        begin // R5 / R6: direction preference and turnaround gap (bank0 holds row 2)
            int s, b, c0, c1, nc;
            s = sv_n; b = next_id; lg_n = 0;
            push_req(0, mk(9, 3, 0, 0));
            push_req(1, mk(2, 0, 1, 0));
            push_req(0, mk(2, 0, 2, 0));
            drain();
            expect_order(s, 3, b, b + 2, b + 1, 0, 0, "R5 same direction first");
            nc = 0; c0 = 0; c1 = 0;
            for (int i = 0; i < lg_n; i++)
                if (lg_op[i] == 1 || lg_op[i] == 2) begin
                    nc++;
                    c0 = c1; c1 = lg_cyc[i];
                end
            chk(nc == 3 && c1 - c0 >= T_TURN, "R6 read to write gap", c1 - c0, T_TURN);
        end

        begin // R9: same address keeps order though younger is a preferred write
            int s, b;
            s = sv_n; b = next_id;
            push_req(1, mk(4, 1, 0, 0));
            push_req(0, mk(2, 0, 6, 0));
            push_req(1, mk(2, 0, 6, 0));
            drain();
            expect_order(s, 3, b, b + 1, b + 2, 0, 0, "R9 arrival order");
        end

        begin // R7 / R10: starvation of a head miss; full queue
            int s, b;
            s = sv_n; b = next_id;
            push_req(0, mk(8, 2, 0, 0));
            push_req(0, mk(3, 0, 0, 0));
            push_req(0, mk(2, 0, 1, 0));
            push_req(0, mk(2, 0, 2, 0));
            chk(req_ready == 1'b0, "R10 ready low when full", req_ready, 0);
            push_req(0, mk(2, 0, 3, 0));
            drain();
            expect_order(s, 5, b, b + 2, b + 3, b + 1, b + 4, "R7 starved head served");
        end

        begin // random mix with frequent hits and collisions
            int pushed, s;
            void'($urandom(32'd24681));
            s = sv_n; pushed = 0;
            for (int i = 0; i < 300; i++) begin
                push_req(int'($urandom % 2),
                         mk(int'($urandom % 3), int'($urandom % 4), int'($urandom % 4),
                            int'($urandom % 32)));
                pushed++;
                repeat (int'($urandom % 3)) @(posedge clk);
                #1;
            end
            drain();
            chk(p_n == 0, "R10 all requests served", p_n, 0);
            chk(next_id - (sv_n - s) == next_id - pushed, "R10 one column each", sv_n - s, pushed);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule